// File: doc/BRIEF.md
# Strobe-Handshake FIFO Buffer

This block is a first-in first-out word buffer with a pulse-strobe handshake on both sides. The producer sees `in_ready` high, raises `shift_in` to hand over a word, and lowers it again to commit that word. The consumer sees `out_ready` high, reads the word already shown on `data_out`, raises `shift_out` to acknowledge it, and lowers it to move on to the next word. Each ready flag drops while its strobe is high. It comes back only after the matching pointer has moved, and only if there is still room (input side) or still data (output side).

All of this runs on one system clock. Both strobes are sampled at every rising clock edge. A strobe edge is detected at the first clock edge that samples the new level, and its effect is registered at that same edge. A word that enters an empty buffer falls through to the output after a fixed number of cycles. A slot that is freed in a full buffer becomes visible to the producer after another fixed number of cycles. Storage is a dual-port memory addressed by write and read pointers, and each pointer carries one extra wrap bit so that full and empty can be told apart. When `out_en` is low, the data bus reads as zero.

Top module: `strobe_fifo`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its state. After that edge `in_ready` is 1, `out_ready` is 0, `data_out` is 0 and `err_pulse` is 0.
- R2: A `shift_in` rising edge detected while `in_ready` is 1 stores `data_in` in the slot at the write pointer, and `in_ready` is 0 after that edge.
- R3: A `shift_in` falling edge that follows an accepted rising edge advances the write pointer. At that same edge `in_ready` returns to 1 unless the buffer now holds DEPTH words, in which case it stays 0. The stored count never exceeds DEPTH.
- R4: While the buffer holds DEPTH words, `in_ready` stays 0. Once a read frees a slot, `in_ready` rises at the FS_LAT-th clock edge after the edge at which the read pointer advanced.
- R5: If `shift_in` is already high at the edge where freed space would raise `in_ready`, `data_in` is stored at that edge and `in_ready` stays 0. No new rising edge is needed, and the following `shift_in` falling edge commits the word.
- R6: A `shift_out` rising edge detected while `out_ready` is 1 drives `out_ready` to 0 at that edge, and `data_out` keeps its value.
- R7: A `shift_out` falling edge that follows an accepted rising edge advances the read pointer. At that same edge, if a word remains, `out_ready` returns to 1 and `data_out` shows that next word. Otherwise `out_ready` stays 0.
- R8: When a word is committed while no word is presented, `data_out` takes that word and `out_ready` rises at the FT_LAT-th clock edge after the edge at which the write pointer advanced.
- R9: When `out_en` is 0, `data_out` is all zeros. The stored words, the flags and the word presented are unchanged when `out_en` returns to 1.
- R10: A `shift_in` rising edge while `in_ready` is 0 (other than the R5 capture) is ignored. A `shift_out` falling edge with no accepted rising edge before it is also ignored. Either one makes `err_pulse` 1 for exactly the one cycle after the edge at which it is detected.
- R11: Words leave in the order they were committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high master reset |
| shift_in | input | 1 | Producer strobe: rising edge stores, falling edge commits |
| data_in | input | WIDTH | Word to be stored |
| in_ready | output | 1 | A free slot is open to the producer |
| shift_out | input | 1 | Consumer strobe: rising edge acknowledges, falling edge advances |
| out_en | input | 1 | Data bus enable; 0 forces `data_out` to zero |
| out_ready | output | 1 | `data_out` holds a valid word |
| data_out | output | WIDTH | Presented word, or zero when disabled |
| err_pulse | output | 1 | One-cycle flag for an ignored strobe edge |

## Verification
The assertions assume that each strobe edge is sampled by the clock as a single level change. They also assume that the producer and the consumer keep to the handshake: a commit follows only an accepted store, and an advance follows only an accepted acknowledge. Under those conditions they hold that the ready flags agree with the fill level. The stimulus moves strobes only at falling clock edges and holds each level for at least one full cycle, so every edge is seen exactly once. Deliberate misuse is limited to the two ignored-edge cases named in R10, and the bench checks those at the ports.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

    // Edge events derived from one sampled strobe
    typedef struct packed {
        logic rise;
        logic fall;
    } strobe_ev_t;

    function automatic strobe_ev_t edge_of(input logic prev, input logic cur);
        strobe_ev_t ev;
        ev.rise = cur & ~prev;
        ev.fall = prev & ~cur;
        return ev;
    endfunction

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge
    import strobe_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       level,
    output strobe_ev_t ev
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= level;
    end

    assign ev = edge_of(level_q, level);
endmodule

// File: rtl/latency_timer.sv
module latency_timer #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = (LAT < 2) ? 1 : $clog2(LAT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start && !busy) begin
            busy  <= 1'b1;
            cnt_q <= CW'(LAT - 1);
        end else if (busy) begin
            if (cnt_q == '0) busy <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = busy && (cnt_q == '0);
endmodule

// File: rtl/fifo_mem.sv
module fifo_mem #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
    import strobe_fifo_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int DEPTH  = 16,
    parameter int FT_LAT = 2,
    parameter int FS_LAT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_in,
    input  logic [WIDTH-1:0] data_in,
    output logic             in_ready,
    input  logic             shift_out,
    input  logic             out_en,
    output logic             out_ready,
    output logic [WIDTH-1:0] data_out,
    output logic             err_pulse
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

    strobe_ev_t si_ev, so_ev;

    logic [PW-1:0]    wptr_q, rptr_q, wptr_n, rptr_n, level_q, level_n;
    logic             ir_q, or_q, wr_pend_q, rd_pend_q, err_q;
    logic             ir_n, or_n, wr_pend_n, rd_pend_n, err_n;
    logic [WIDTH-1:0] dout_q, dout_n, rd_word;
    logic             ft_start, ft_busy, ft_done;
    logic             fs_start, fs_busy, fs_done;
    logic             wr_accept, fs_cap, fs_open, mem_we;
    logic             wr_commit, rd_start, rd_commit, full_n;
    logic [AW-1:0]    rd_addr;

    strobe_edge u_si_edge (.clk(clk), .rst(rst), .level(shift_in),  .ev(si_ev));
    strobe_edge u_so_edge (.clk(clk), .rst(rst), .level(shift_out), .ev(so_ev));

    latency_timer #(.LAT(FT_LAT)) u_ft_timer (
        .clk(clk), .rst(rst), .start(ft_start), .busy(ft_busy), .done(ft_done));
    latency_timer #(.LAT(FS_LAT)) u_fs_timer (
        .clk(clk), .rst(rst), .start(fs_start), .busy(fs_busy), .done(fs_done));

    fifo_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .we(mem_we), .waddr(wptr_q[AW-1:0]), .wdata(data_in),
        .raddr(rd_addr), .rdata(rd_word));

    assign level_q = wptr_q - rptr_q;

    always_comb begin
        // producer side
        wr_accept = si_ev.rise && ir_q;
        fs_cap    = fs_done && shift_in;
        fs_open   = fs_done && !shift_in;
        mem_we    = wr_accept || fs_cap;
        wr_commit = si_ev.fall && wr_pend_q;
        // consumer side
        rd_start  = so_ev.rise && or_q;
        rd_commit = so_ev.fall && rd_pend_q;
        err_n     = (si_ev.rise && !ir_q && !fs_done) || (so_ev.fall && !rd_pend_q);

        wptr_n  = wptr_q + PW'(wr_commit);
        rptr_n  = rptr_q + PW'(rd_commit);
        level_n = wptr_n - rptr_n;
        full_n  = (level_n == FULL_LVL);

        if (mem_we)         ir_n = 1'b0;
        else if (wr_commit) ir_n = !full_n;
        else if (fs_open)   ir_n = 1'b1;
        else                ir_n = ir_q;

        if (mem_we)         wr_pend_n = 1'b1;
        else if (wr_commit) wr_pend_n = 1'b0;
        else                wr_pend_n = wr_pend_q;

        if (rd_start)       or_n = 1'b0;
        else if (rd_commit) or_n = (level_n != '0);
        else if (ft_done)   or_n = 1'b1;
        else                or_n = or_q;

        if (rd_start)       rd_pend_n = 1'b1;
        else if (rd_commit) rd_pend_n = 1'b0;
        else                rd_pend_n = rd_pend_q;

        rd_addr = rd_commit ? rptr_n[AW-1:0] : rptr_q[AW-1:0];
        if ((rd_commit && level_n != '0) || ft_done) dout_n = rd_word;
        else                                         dout_n = dout_q;

        fs_start = !ir_n && !wr_pend_n && !full_n && !fs_busy;
        ft_start = !or_n && !rd_pend_n && (level_n != '0) && !ft_busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q    <= '0;
            rptr_q    <= '0;
            ir_q      <= 1'b1;
            or_q      <= 1'b0;
            wr_pend_q <= 1'b0;
            rd_pend_q <= 1'b0;
            err_q     <= 1'b0;
            dout_q    <= '0;
        end else begin
            wptr_q    <= wptr_n;
            rptr_q    <= rptr_n;
            ir_q      <= ir_n;
            or_q      <= or_n;
            wr_pend_q <= wr_pend_n;
            rd_pend_q <= rd_pend_n;
            err_q     <= err_n;
            dout_q    <= dout_n;
        end
    end

    assign in_ready  = ir_q;
    assign out_ready = or_q;
    assign err_pulse = err_q;
    assign data_out  = out_en ? dout_q : '0;

    // R2: an accepted store closes the input side on the next cycle
    assert_store_drops_ready_R2: assert property (@(posedge clk) disable iff (rst)
        (si_ev.rise && ir_q) |=> !ir_q);
    // R3: the fill level stays within the storage
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        level_q <= FULL_LVL);
    // R4: a full buffer never advertises space
    assert_full_blocks_input_R4: assert property (@(posedge clk) disable iff (rst)
        (level_q == FULL_LVL) |-> !ir_q);
    // R6: an acknowledge drops the output flag
    assert_ack_drops_ready_R6: assert property (@(posedge clk) disable iff (rst)
        (so_ev.rise && or_q) |=> !or_q);
    // R7: an empty buffer never presents a word
    assert_empty_blocks_output_R7: assert property (@(posedge clk) disable iff (rst)
        (level_q == '0) |-> !or_q);
endmodule

// File: tb/strobe_fifo_bench.sv
module strobe_fifo_bench;
    localparam int W = 8;
    localparam int D = 16;
    // vector: {op[1:0], data[7:0], exp_ir, exp_or, exp_dout[7:0]}
    // op 0 = store word, 1 = take word (data = word expected before take), 2 = idle data cycles
    localparam logic [19:0] VEC [8] = '{
        {2'd0, 8'hA5, 1'b1, 1'b0, 8'h00},
        {2'd2, 8'd2,  1'b1, 1'b1, 8'hA5},
        {2'd0, 8'h3C, 1'b1, 1'b1, 8'hA5},
        {2'd0, 8'h77, 1'b1, 1'b1, 8'hA5},
        {2'd1, 8'hA5, 1'b1, 1'b1, 8'h3C},
        {2'd1, 8'h3C, 1'b1, 1'b1, 8'h77},
        {2'd1, 8'h77, 1'b1, 1'b0, 8'h77},
        {2'd2, 8'd3,  1'b1, 1'b0, 8'h77}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         shift_in = 1'b0;
    logic         shift_out = 1'b0;
    logic         out_en = 1'b1;
    logic [W-1:0] data_in = '0;
    logic         in_ready, out_ready, err_pulse;
    logic [W-1:0] data_out;
    logic [19:0]  v;
    logic [W-1:0] exp_w;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    strobe_fifo #(.WIDTH(W), .DEPTH(D), .FT_LAT(2), .FS_LAT(2)) u_strobe_fifo (
        .clk(clk), .rst(rst), .shift_in(shift_in), .data_in(data_in),
        .in_ready(in_ready), .shift_out(shift_out), .out_en(out_en),
        .out_ready(out_ready), .data_out(data_out), .err_pulse(err_pulse));

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic store(input logic [W-1:0] d);
        data_in = d;
        shift_in = 1'b1;
        @(negedge clk);
        shift_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic take();
        shift_out = 1'b1;
        @(negedge clk);
        shift_out = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(in_ready, 1, "R1 in_ready");
        chk(out_ready, 0, "R1 out_ready");
        chk(data_out, 0, "R1 data_out");
        chk(err_pulse, 0, "R1 err_pulse");

        // vector walk: R3, R7, R8, R11
        for (int i = 0; i < 8; i++) begin
            v = VEC[i];
            case (v[19:18])
                2'd0: store(v[17:10]);
                2'd1: begin
                    chk(data_out, v[17:10], "R11 word order");
                    take();
                end
                default: repeat (int'(v[17:10])) @(negedge clk);
            endcase
            chk(in_ready, v[9], "R3 vector in_ready");
            chk(out_ready, v[8], "R7 vector out_ready");
            chk(data_out, v[7:0], "R8 vector data_out");
        end

        // R2, R3, R8 exact fall-through timing
        data_in = 8'h5A;
        shift_in = 1'b1;
        @(negedge clk);
        chk(in_ready, 0, "R2 store closes input");
        shift_in = 1'b0;
        @(negedge clk);
        chk(in_ready, 1, "R3 commit reopens input");
        chk(out_ready, 0, "R8 not yet presented");
        @(negedge clk);
        chk(out_ready, 0, "R8 first latency cycle");
        @(negedge clk);
        chk(out_ready, 1, "R8 presented");
        chk(data_out, 8'h5A, "R8 fall-through word");

        // R9 output enable
        out_en = 1'b0;
        @(negedge clk);
        chk(data_out, 0, "R9 disabled bus");
        chk(out_ready, 1, "R9 flag kept");
        out_en = 1'b1;
        @(negedge clk);
        chk(data_out, 8'h5A, "R9 word kept");

        // R6 acknowledge, R7 empty after last word
        shift_out = 1'b1;
        @(negedge clk);
        chk(out_ready, 0, "R6 acknowledge drops flag");
        chk(data_out, 8'h5A, "R6 word held");
        shift_out = 1'b0;
        @(negedge clk);
        chk(out_ready, 0, "R7 empty stays low");

        // R10 advance with no acknowledge
        shift_out = 1'b1;
        @(negedge clk);
        shift_out = 1'b0;
        @(negedge clk);
        chk(err_pulse, 1, "R10 stray advance flagged");
        @(negedge clk);
        chk(err_pulse, 0, "R10 one-cycle pulse");
        chk(out_ready, 0, "R10 no flag change");
        store(8'h99);
        repeat (2) @(negedge clk);
        chk(data_out, 8'h99, "R10 read pointer unmoved");
        take();

        // R3, R4 fill to capacity
        for (int i = 0; i < D; i++) begin
            store(W'(8'h40 + i));
            if (i == D - 2) chk(in_ready, 1, "R3 one slot left");
            if (i == D - 1) chk(in_ready, 0, "R3 full closes input");
        end
        repeat (4) @(negedge clk);
        chk(in_ready, 0, "R4 full stays closed");

        // R10 store while full, held high for R5 capture
        data_in = 8'hEE;
        shift_in = 1'b1;
        @(negedge clk);
        chk(err_pulse, 1, "R10 store while full flagged");
        chk(in_ready, 0, "R10 input still closed");
        chk(data_out, 8'h40, "R11 head word");
        take();
        repeat (3) @(negedge clk);
        shift_in = 1'b0;
        @(negedge clk);
        chk(in_ready, 0, "R5 captured word refilled buffer");

        // drain: R4 freed-space timing, R5 captured word, R11 order
        for (int k = 0; k < D; k++) begin
            exp_w = (k < D - 1) ? W'(8'h41 + k) : 8'hEE;
            chk(out_ready, 1, "R11 word available");
            chk(data_out, exp_w, (k < D - 1) ? "R11 drain order" : "R5 captured word");
            take();
            if (k == 0) begin
                chk(in_ready, 0, "R4 freed space latency 0");
                @(negedge clk);
                chk(in_ready, 0, "R4 freed space latency 1");
                @(negedge clk);
                chk(in_ready, 1, "R4 freed space visible");
            end
        end
        chk(out_ready, 0, "R7 drained empty");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule